// File: doc/BRIEF.md
# Timestamped Request Replay Engine

This block plays back a recorded sequence of memory transactions onto a request port. Each entry comes in on a valid/ready stream and carries a cycle stamp, a read/write bit, an address, an optional byte length with a flag that says whether the length is present, and a marker for the final entry. The engine keeps one entry at a time. It offers that entry as a request once its stamp is due. The entry stream is back-pressured: `ent_ready` is high only when the holding slot is empty, and an entry is taken on a rising edge where both `ent_valid` and `ent_ready` are high.

There are two timing modes. In absolute mode (`rel_mode` = 0), the stamp names a cycle of a free-running counter that starts at reset release. In relative mode (`rel_mode` = 1), the stamp is a delay. The first delay counts from reset release. Every later delay counts from the response strobe of the previous transaction, so the replay slows down when the memory slows down. Cycle 0 is the first clock cycle with `rst_n` high, and the count advances by one at each rising edge. The request port is valid/ready: a request stays asserted with stable fields until `req_ready` accepts it. `rsp_valid` is a one-cycle completion strobe, one per accepted request.

Top module: `stamp_replay`

## Requirements
- R1: During and right after reset, `ent_ready` = 1, `req_valid` = 0, `late` = 0 and `done` = 0.
- R2: In absolute mode, an entry with stamp S that is held before cycle S raises `req_valid` first in cycle S and never earlier.
- R3: In absolute mode, an entry whose first held cycle is after its stamp is offered in that first held cycle, and `late` is set from the next cycle on and stays set until reset.
- R4: In relative mode, the first entry is offered in cycle max(S, first held cycle).
- R5: In relative mode, no request is offered while a response is pending. After the response strobe in cycle r, the next entry is offered in cycle max(r + max(S,1), first held cycle).
- R6: `req_len` equals `ent_len` when `ent_len_en` = 1, and equals DEFAULT_LEN (32) otherwise. `req_write` and `req_addr` carry the entry's type (1 = write) and address.
- R7: Entries produce exactly one request each, in input order. While `req_valid` = 1 and `req_ready` = 0, the request and its fields do not change.
- R8: The absolute counter keeps running while a request is stalled. A stall past the stamp does not set `late`, and the next entry keeps its own absolute timing.
- R9: An entry taken at a rising edge makes `ent_ready` 0 from the next cycle until the rising edge that completes its request handshake.
- R10: `done` rises in the cycle after the response strobe that leaves no pending responses, once the entry marked by `ent_last` has been issued, and it stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rel_mode | input | 1 | 0 = absolute stamps, 1 = relative delays; held constant between resets |
| ent_valid | input | 1 | Entry stream valid |
| ent_ready | output | 1 | Entry stream ready (holding slot empty) |
| ent_stamp | input | STAMP_W (16) | Cycle stamp or delay |
| ent_write | input | 1 | 1 = write, 0 = read |
| ent_addr | input | ADDR_W (32) | Transaction address |
| ent_len | input | LEN_W (16) | Byte length, used when ent_len_en = 1 |
| ent_len_en | input | 1 | Length field present |
| ent_last | input | 1 | Marks the final entry |
| req_valid | output | 1 | Request valid |
| req_ready | input | 1 | Request accepted by the port |
| req_write | output | 1 | Request type, 1 = write |
| req_addr | output | ADDR_W (32) | Request address |
| req_len | output | LEN_W (16) | Request byte length |
| rsp_valid | input | 1 | One-cycle completion strobe |
| late | output | 1 | Sticky: an absolute entry was offered after its stamp |
| done | output | 1 | Sticky: final entry completed, nothing pending |

## Verification
The in-RTL properties assume that `rel_mode` only changes while reset is held, and that `rsp_valid` pulses once for each accepted request and never when nothing is pending. Under these assumptions the pending count cannot underflow, and at most one response is outstanding in relative mode. The bench keeps within these assumptions. It sets the mode only during reset. Its responder derives each strobe from an observed request handshake after a fixed latency. It changes `req_ready` only at falling edges, and it holds it low over a window that spans a stamp, so the stall behaviour is exercised without breaking the request-hold rule.

// File: rtl/replay_pkg.sv
package replay_pkg;

  typedef enum logic {
    TMODE_ABS = 1'b0,
    TMODE_REL = 1'b1
  } tmode_e;

endpackage

// File: rtl/replay_timer.sv
module replay_timer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rsp_valid,
  output logic [CNT_W-1:0] abs_cnt,
  output logic [CNT_W-1:0] rel_cnt
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // absolute counter: cycles since reset release, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      abs_cnt <= '0;
    end else if (abs_cnt != CNT_MAX) begin
      abs_cnt <= abs_cnt + CNT_ONE;
    end
  end

  // relative counter: the strobe cycle counts as delay 0
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_cnt <= '0;
    end else if (rsp_valid) begin
      rel_cnt <= CNT_ONE;
    end else if (rel_cnt != CNT_MAX) begin
      rel_cnt <= rel_cnt + CNT_ONE;
    end
  end

endmodule

// File: rtl/replay_slot.sv
module replay_slot #(
  parameter int STAMP_W     = 16,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int DEFAULT_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ent_valid,
  output logic               ent_ready,
  input  logic [STAMP_W-1:0] ent_stamp,
  input  logic               ent_write,
  input  logic [ADDR_W-1:0]  ent_addr,
  input  logic [LEN_W-1:0]   ent_len,
  input  logic               ent_len_en,
  input  logic               ent_last,
  input  logic               due,
  input  logic               req_ready,
  output logic               req_valid,
  output logic               req_write,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [LEN_W-1:0]   req_len,
  output logic [STAMP_W-1:0] held_stamp,
  output logic               held_last,
  output logic               first_offer,
  output logic               fire
);

  localparam logic [LEN_W-1:0] LEN_DFLT = LEN_W'(DEFAULT_LEN);

  logic full_q;
  logic offered_q;
  logic take;

  assign ent_ready   = !full_q;
  assign take        = ent_valid && ent_ready;
  assign req_valid   = full_q && due;
  assign fire        = req_valid && req_ready;
  assign first_offer = req_valid && !offered_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q     <= 1'b0;
      offered_q  <= 1'b0;
      held_stamp <= '0;
      held_last  <= 1'b0;
      req_write  <= 1'b0;
      req_addr   <= '0;
      req_len    <= '0;
    end else begin
      if (fire) begin
        full_q    <= 1'b0;
        offered_q <= 1'b0;
      end else if (req_valid) begin
        offered_q <= 1'b1;
      end
      if (take) begin
        full_q     <= 1'b1;
        held_stamp <= ent_stamp;
        held_last  <= ent_last;
        req_write  <= ent_write;
        req_addr   <= ent_addr;
        req_len    <= ent_len_en ? ent_len : LEN_DFLT;
      end
    end
  end

  // R7: a stalled request keeps its valid and its fields
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_write) && $stable(req_len)));

  // R9: taking an entry closes the input until the handshake
  assert_accept_closes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_valid && ent_ready) |=> !ent_ready);

endmodule

// File: rtl/replay_track.sv
module replay_track #(
  parameter int STAMP_W = 16,
  parameter int CNT_W   = 32,
  parameter int PEND_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rel_mode,
  input  logic [CNT_W-1:0]   abs_cnt,
  input  logic [CNT_W-1:0]   rel_cnt,
  input  logic [STAMP_W-1:0] held_stamp,
  input  logic               held_last,
  input  logic               first_offer,
  input  logic               fire,
  input  logic               rsp_valid,
  output logic               due,
  output logic [PEND_W-1:0]  pend,
  output logic               late,
  output logic               done
);

  import replay_pkg::*;

  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

  tmode_e            mode;
  logic [CNT_W-1:0]  stamp_x;
  logic              abs_due;
  logic              rel_due;
  logic              rsp_ok;
  logic [PEND_W-1:0] pend_nxt;
  logic              sent_last_q;

  assign mode    = rel_mode ? TMODE_REL : TMODE_ABS;
  assign stamp_x = CNT_W'(held_stamp);
  assign abs_due = (abs_cnt >= stamp_x) && (pend != PEND_MAX);
  assign rel_due = (pend == '0) && (rel_cnt >= stamp_x);
  assign due     = (mode == TMODE_REL) ? rel_due : abs_due;
  assign rsp_ok  = rsp_valid && (pend != '0);

  always_comb begin
    unique case ({fire, rsp_ok})
      2'b10:   pend_nxt = pend + PEND_ONE;
      2'b01:   pend_nxt = pend - PEND_ONE;
      default: pend_nxt = pend;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend        <= '0;
      sent_last_q <= 1'b0;
      late        <= 1'b0;
      done        <= 1'b0;
    end else begin
      pend <= pend_nxt;
      if (fire && held_last) begin
        sent_last_q <= 1'b1;
      end
      if (first_offer && (mode == TMODE_ABS) && (abs_cnt > stamp_x)) begin
        late <= 1'b1;
      end
      if ((sent_last_q || (fire && held_last)) && (pend_nxt == '0)) begin
        done <= 1'b1;
      end
    end
  end

  // R3: the late flag never clears on its own
  assert_late_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    late |=> late);

  // R10: done never clears on its own
  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R10: done only rises on a cycle that carried a completion strobe
  assert_done_after_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rsp_valid));

endmodule

// File: rtl/stamp_replay.sv
module stamp_replay #(
  parameter int STAMP_W     = 16,
  parameter int ADDR_W      = 32,
  parameter int LEN_W       = 16,
  parameter int CNT_W       = 32,
  parameter int PEND_W      = 8,
  parameter int DEFAULT_LEN = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rel_mode,
  input  logic               ent_valid,
  output logic               ent_ready,
  input  logic [STAMP_W-1:0] ent_stamp,
  input  logic               ent_write,
  input  logic [ADDR_W-1:0]  ent_addr,
  input  logic [LEN_W-1:0]   ent_len,
  input  logic               ent_len_en,
  input  logic               ent_last,
  output logic               req_valid,
  input  logic               req_ready,
  output logic               req_write,
  output logic [ADDR_W-1:0]  req_addr,
  output logic [LEN_W-1:0]   req_len,
  input  logic               rsp_valid,
  output logic               late,
  output logic               done
);

  logic [CNT_W-1:0]   abs_cnt;
  logic [CNT_W-1:0]   rel_cnt;
  logic [STAMP_W-1:0] held_stamp;
  logic               held_last;
  logic               first_offer;
  logic               fire;
  logic               due;
  logic [PEND_W-1:0]  pend;

  replay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .rsp_valid (rsp_valid),
    .abs_cnt   (abs_cnt),
    .rel_cnt   (rel_cnt)
  );

  replay_slot #(
    .STAMP_W     (STAMP_W),
    .ADDR_W      (ADDR_W),
    .LEN_W       (LEN_W),
    .DEFAULT_LEN (DEFAULT_LEN)
  ) u_slot (
    .clk         (clk),
    .rst_n       (rst_n),
    .ent_valid   (ent_valid),
    .ent_ready   (ent_ready),
    .ent_stamp   (ent_stamp),
    .ent_write   (ent_write),
    .ent_addr    (ent_addr),
    .ent_len     (ent_len),
    .ent_len_en  (ent_len_en),
    .ent_last    (ent_last),
    .due         (due),
    .req_ready   (req_ready),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_len     (req_len),
    .held_stamp  (held_stamp),
    .held_last   (held_last),
    .first_offer (first_offer),
    .fire        (fire)
  );

  replay_track #(
    .STAMP_W (STAMP_W),
    .CNT_W   (CNT_W),
    .PEND_W  (PEND_W)
  ) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .rel_mode    (rel_mode),
    .abs_cnt     (abs_cnt),
    .rel_cnt     (rel_cnt),
    .held_stamp  (held_stamp),
    .held_last   (held_last),
    .first_offer (first_offer),
    .fire        (fire),
    .rsp_valid   (rsp_valid),
    .due         (due),
    .pend        (pend),
    .late        (late),
    .done        (done)
  );

  // R5: relative mode never offers while a response is pending
  assert_one_outstanding_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_mode && (pend != '0)) |-> !req_valid);

  // R2: absolute mode never offers ahead of the stamp
  assert_not_early_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!rel_mode && req_valid) |-> (abs_cnt >= CNT_W'(held_stamp)));

endmodule

// File: tb/tb_stamp_replay.sv
module tb_stamp_replay;

  typedef struct packed {
    logic [15:0] stamp;
    logic        wr;
    logic [31:0] addr;
    logic [15:0] len;
    logic        len_en;
    logic        last;
    logic [15:0] ecyc;
    logic        elate;
  } vec_t;

  // 0..5 absolute, 6..9 relative, 10..11 stall (absolute)
  localparam vec_t TAB [12] = '{
    '{16'd5,  1'b0, 32'h1000, 16'd0,   1'b0, 1'b0, 16'd5,  1'b0},
    '{16'd9,  1'b1, 32'h1040, 16'd0,   1'b0, 1'b0, 16'd9,  1'b0},
    '{16'd9,  1'b0, 32'h2000, 16'd0,   1'b0, 1'b0, 16'd11, 1'b1},
    '{16'd20, 1'b1, 32'h2080, 16'd64,  1'b1, 1'b0, 16'd20, 1'b1},
    '{16'd21, 1'b0, 32'h3000, 16'd128, 1'b1, 1'b0, 16'd22, 1'b1},
    '{16'd40, 1'b0, 32'h3100, 16'd0,   1'b0, 1'b1, 16'd40, 1'b1},
    '{16'd4,  1'b0, 32'h0400, 16'd0,   1'b0, 1'b0, 16'd4,  1'b0},
    '{16'd2,  1'b1, 32'h0440, 16'd16,  1'b1, 1'b0, 16'd9,  1'b0},
    '{16'd0,  1'b0, 32'h0480, 16'd0,   1'b0, 1'b0, 16'd13, 1'b0},
    '{16'd1,  1'b1, 32'h04c0, 16'd0,   1'b0, 1'b1, 16'd17, 1'b0},
    '{16'd6,  1'b1, 32'h0800, 16'd0,   1'b0, 1'b0, 16'd12, 1'b0},
    '{16'd14, 1'b0, 32'h0840, 16'd8,   1'b1, 1'b1, 16'd14, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rel_mode = 1'b0;
  logic        ent_valid = 1'b0;
  logic        ent_ready;
  logic [15:0] ent_stamp = '0;
  logic        ent_write = 1'b0;
  logic [31:0] ent_addr = '0;
  logic [15:0] ent_len = '0;
  logic        ent_len_en = 1'b0;
  logic        ent_last = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_write;
  logic [31:0] req_addr;
  logic [15:0] req_len;
  logic        rsp_valid = 1'b0;
  logic        late;
  logic        done;

  int checks = 0;
  int fails  = 0;
  int tcyc   = 0;

  stamp_replay dut (
    .clk(clk), .rst_n(rst_n), .rel_mode(rel_mode),
    .ent_valid(ent_valid), .ent_ready(ent_ready), .ent_stamp(ent_stamp),
    .ent_write(ent_write), .ent_addr(ent_addr), .ent_len(ent_len),
    .ent_len_en(ent_len_en), .ent_last(ent_last),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid),
    .late(late), .done(done)
  );

  always #4 clk = ~clk;

  // reference cycle index: 0 in the first cycle after reset release
  always @(posedge clk) begin
    if (!rst_n) tcyc <= 0;
    else        tcyc <= tcyc + 1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual=%0h expected=%0h",
               req, what, tcyc, act, exp);
    end
  endtask

  task automatic wait_cyc(input int c);
    while (tcyc != c) @(negedge clk);
  endtask

  task automatic do_reset(input logic mode);
    @(negedge clk);
    rst_n = 1'b0;
    rel_mode = mode;
    ent_valid = 1'b0;
    rsp_valid = 1'b0;
    req_ready = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state while reset is held
    check(ent_ready == 1'b1 && req_valid == 1'b0 && late == 1'b0 && done == 1'b0,
          "R1", "reset outputs", {ent_ready, req_valid, late, done}, 4'b1000);
    rst_n = 1'b1;
  endtask

  task automatic drive(input int first, input int cnt);
    for (int i = first; i < first + cnt; i++) begin
      bit ok;
      ent_valid  = 1'b1;
      ent_stamp  = TAB[i].stamp;
      ent_write  = TAB[i].wr;
      ent_addr   = TAB[i].addr;
      ent_len    = TAB[i].len;
      ent_len_en = TAB[i].len_en;
      ent_last   = TAB[i].last;
      forever begin
        ok = ent_ready;
        @(posedge clk);
        if (ok) break;
        @(negedge clk);
      end
      @(negedge clk);
    end
    ent_valid = 1'b0;
  endtask

  task automatic monitor(input int first, input int cnt, input int lat,
                         input int stall_until);
    int got = 0;
    int late_idx = -1;
    int tail = 0;
    logic [15:0] hist = '0;
    while (got < cnt || tail < lat + 2) begin
      bit hs;
      if (got >= cnt) tail++;
      req_ready = (tcyc >= stall_until);
      if (late_idx >= 0) begin
        // R3: late flag one cycle after the offer
        check(late == TAB[late_idx].elate, "R3", "late flag",
              late, TAB[late_idx].elate);
        late_idx = -1;
      end
      hs = req_valid && req_ready;
      if (hs && got < cnt) begin
        int k = first + got;
        logic [15:0] elen = TAB[k].len_en ? TAB[k].len : 16'd32;
        // R2 R4 R5: issue cycle; R7: order via table index
        check(tcyc == int'(TAB[k].ecyc), "R2/R4/R5", "issue cycle",
              tcyc, TAB[k].ecyc);
        check(req_addr == TAB[k].addr && req_write == TAB[k].wr, "R7",
              "request order/addr", req_addr, TAB[k].addr);
        check(req_len == elen, "R6", "request length", req_len, elen);
        check(done == 1'b0, "R10", "done before final completion", done, 0);
        late_idx = k;
        got++;
      end
      hist = {hist[14:0], hs};
      rsp_valid = hist[lat];
      @(negedge clk);
    end
    rsp_valid = 1'b0;
  endtask

  task automatic watch_done(input int d);
    wait_cyc(d - 1);
    check(done == 1'b0, "R10", "done one cycle early", done, 0);
    wait_cyc(d);
    check(done == 1'b1, "R10", "done after final strobe", done, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R10 watchdog expired: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // absolute table walk
    do_reset(1'b0);
    req_ready = 1'b1;
    fork
      drive(0, 6);
      monitor(0, 6, 2, 0);
      watch_done(43);
      begin
        // R9: slot closed while the first entry waits
        wait_cyc(3);
        check(ent_ready == 1'b0, "R9", "input closed while held", ent_ready, 0);
        wait_cyc(6);
        check(ent_ready == 1'b1, "R9", "input open after handshake", ent_ready, 1);
      end
    join
    check(late == 1'b1, "R3", "late stays set", late, 1);

    // relative table walk
    do_reset(1'b1);
    req_ready = 1'b1;
    fork
      drive(6, 4);
      monitor(6, 4, 3, 0);
      watch_done(21);
      begin
        // R5: nothing offered while the first response is pending
        wait_cyc(7);
        check(req_valid == 1'b0, "R5", "no offer while pending", req_valid, 0);
        wait_cyc(8);
        check(req_valid == 1'b0, "R5", "delay counts from strobe", req_valid, 0);
      end
    join
    check(late == 1'b0, "R4", "relative mode never late", late, 0);

    // stall across the stamp in absolute mode
    do_reset(1'b0);
    fork
      drive(10, 2);
      monitor(10, 2, 2, 12);
      watch_done(17);
      begin
        wait_cyc(5);
        check(req_valid == 1'b0, "R2", "not offered before stamp", req_valid, 0);
        wait_cyc(6);
        check(req_valid == 1'b1, "R2", "offered at stamp", req_valid, 1);
        wait_cyc(9);
        check(req_valid == 1'b1 && req_addr == 32'h0800, "R7",
              "request held during stall", req_addr, 32'h0800);
      end
    join
    check(late == 1'b0, "R8", "stall does not set late", late, 0);

    // R1: reset clears sticky flags
    do_reset(1'b0);
    @(negedge clk);
    check(done == 1'b0 && late == 1'b0 && ent_ready == 1'b1, "R1",
          "state after release", {done, late, ent_ready}, 3'b001);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule